// File: doc/BRIEF.md
# Phase-Shifted Clock Divider with Degree Conversion

This block runs on a fast source clock and produces a divided clock whose phase can be moved in steps of one source period. It drives two clocks. `clk_ref` is the divided clock with no shift. `clk_out` is the same clock delayed by a programmable number of source cycles. The divide ratio R is the integer quotient of two rate inputs, `src_rate / out_rate`. The delay code sits in a field of a 32-bit control register. A code of zero does not mean "no shift": it selects a half-period (180 degree) shift.

Software can write the whole control register at once. It can also ask for a phase in degrees. A small sequencer handles a degree request. It has five states:

- `S_IDLE` waits. It moves to `S_STEP` when `set_req` arrives.
- `S_STEP` works out the degree step for R. It moves to `S_FAIL` if a rate is unusable, otherwise to `S_CODE`.
- `S_CODE` rounds the request to a code and moves to `S_COMMIT`.
- `S_COMMIT` does a read-modify-write of the field only, then returns to `S_IDLE`.
- `S_FAIL` reports an error and returns to `S_IDLE`.

Separately from the sequencer, the current code is converted back to degrees on every cycle. The result appears on `phase_deg`.

Top module: `phase_clk_out`

## Requirements
- R1: `clk_ref` has a period of R = floor(src_rate/out_rate) source cycles and is high for floor(R/2) of them. When R < 2, both clocks stay low.
- R2: A nonzero code C makes the rising edge of `clk_out` lag the rising edge of `clk_ref` by C mod R source cycles.
- R3: Code 0 makes the lag floor(R/2) cycles. `phase_deg` then reads 180 and `phase_err` is 0, even when a rate is zero.
- R4: The step is round(360/R), with halves rounded up. For a nonzero code, `phase_deg` equals code × step. `phase_deg` updates one cycle after the register changes.
- R5: A request for exactly 180 degrees writes code 0. Any other request writes round(deg/step), with halves rounded up, and saturates at 2^FIELD_W−1 (15 by default).
- R6: A degree request changes only bits [FIELD_LSB+FIELD_W−1:FIELD_LSB] of the register (bits [11:8] by default). Every other bit keeps its value.
- R7: The request fails when `src_rate` is 0, `out_rate` is 0, R is 0, or the step rounds to 0. A failed request pulses `set_done` together with `set_err` and leaves the register unchanged. `phase_err` is 1 when the code is nonzero and the rates are unusable.
- R8: An accepted request pulses `set_done` for one cycle. The pulse comes 3 clocks after `set_req` is sampled on success and 2 clocks after on failure. `set_req` is ignored while the sequencer is busy.
- R9: A new ratio or code takes effect only when the phase counter wraps at the end of a period.
- R10: After reset the register reads 0. A `reg_wr` pulse replaces the whole register, and the new value is seen on `reg_rdata` after that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_rate | input | RATE_W | Source clock rate |
| out_rate | input | RATE_W | Divided clock rate |
| reg_wr | input | 1 | Full register write strobe |
| reg_wdata | input | 32 | Full register write value |
| reg_rdata | output | 32 | Control register contents |
| set_req | input | 1 | Start a degree request |
| set_deg | input | DEG_W | Requested phase in degrees |
| set_done | output | 1 | Request finished (one-cycle pulse) |
| set_err | output | 1 | Request failed (valid with set_done) |
| phase_deg | output | FIELD_W+9 | Current phase in degrees |
| phase_err | output | 1 | Current phase cannot be converted |
| clk_ref | output | 1 | Divided clock, unshifted |
| clk_out | output | 1 | Divided clock, shifted |

## Verification
Each internal fault shows at the ports within a short, bounded time:

- A wrong latched ratio or delay in the phase counter shows up within about one divided period. The period of `clk_ref` changes, or the lag from `clk_ref` to `clk_out` differs from C mod R.
- A sequencer stuck in a state, or skipping one, shows up three or four clocks after `set_req`. `set_done` arrives at the wrong time or never arrives.
- A wrong rounded step or code shows up on `reg_rdata` at the same `set_done`, and on `phase_deg` one clock later.
- A read-modify-write that spills out of the field changes a neighbouring bit of `reg_rdata` at that same point.

// File: rtl/phase_clk_pkg.sv
package phase_clk_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STEP,
        S_CODE,
        S_COMMIT,
        S_FAIL
    } set_state_t;

    // nearest-integer quotient, halves rounded up; zero divisor yields zero
    function automatic logic [31:0] div_near(input logic [31:0] num, input logic [31:0] den);
        if (den == 32'd0) return 32'd0;
        return (num + (den >> 1)) / den;
    endfunction

endpackage

// File: rtl/phase_math.sv
module phase_math #(
    parameter int RATE_W = 16
) (
    input  logic [RATE_W-1:0] src_rate,
    input  logic [RATE_W-1:0] out_rate,
    output logic [RATE_W-1:0] ratio,
    output logic [8:0]        step,
    output logic              bad
);
    import phase_clk_pkg::*;

    always_comb begin
        ratio = (out_rate == '0) ? '0 : RATE_W'(src_rate / out_rate);
        step  = 9'(div_near(32'd360, 32'(ratio)));
        bad   = (src_rate == '0) || (out_rate == '0) || (ratio == '0) || (step == '0);
    end
endmodule

// File: rtl/phase_field.sv
module phase_field #(
    parameter int FIELD_LSB = 8,
    parameter int FIELD_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_all,
    input  logic [31:0]        wdata,
    input  logic               fld_we,
    input  logic [FIELD_W-1:0] fld_val,
    output logic [31:0]        ctrl
);
    localparam logic [31:0] FMASK = ((32'd1 << FIELD_W) - 32'd1) << FIELD_LSB;

    logic [31:0] nxt;

    always_comb begin
        nxt = wr_all ? wdata : ctrl;
        if (fld_we) nxt[FIELD_LSB +: FIELD_W] = fld_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl <= '0;
        else        ctrl <= nxt;
    end

    p_keep_others_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_we && !wr_all) |=> ((ctrl & ~FMASK) == ($past(ctrl) & ~FMASK)));
endmodule

// File: rtl/phase_div.sv
module phase_div #(
    parameter int RATE_W  = 16,
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATE_W-1:0]  ratio_in,
    input  logic [FIELD_W-1:0] code_in,
    output logic               clk_ref,
    output logic               clk_out
);
    logic [RATE_W-1:0] r_act, d_act, cnt, half, d_cmd, d_new;
    logic [RATE_W:0]   pos;
    logic              run, boundary;

    always_comb begin
        run      = (r_act >= RATE_W'(2));
        boundary = !run || (cnt == r_act - RATE_W'(1));
        d_cmd    = (code_in == '0) ? (ratio_in >> 1) : RATE_W'(code_in);
        d_new    = (ratio_in >= RATE_W'(2)) ? (d_cmd % ratio_in) : '0;
        half     = r_act >> 1;
        if (cnt >= d_act) pos = {1'b0, cnt} - {1'b0, d_act};
        else              pos = {1'b0, cnt} + {1'b0, r_act} - {1'b0, d_act};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_act <= '0;
            d_act <= '0;
            cnt   <= '0;
        end else if (boundary) begin
            r_act <= ratio_in;
            d_act <= d_new;
            cnt   <= '0;
        end else begin
            cnt <= cnt + RATE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_ref <= 1'b0;
            clk_out <= 1'b0;
        end else begin
            clk_ref <= run && (cnt < half);
            clk_out <= run && (pos < {1'b0, half});
        end
    end

    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < r_act));
    p_dly_below_ratio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (d_act < r_act));
    p_hold_until_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> ($stable(r_act) && $stable(d_act)));
endmodule

// File: rtl/phase_clk_out.sv
module phase_clk_out #(
    parameter int RATE_W    = 16,
    parameter int FIELD_LSB = 8,
    parameter int FIELD_W   = 4,
    parameter int DEG_W     = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RATE_W-1:0]    src_rate,
    input  logic [RATE_W-1:0]    out_rate,
    input  logic                 reg_wr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 set_req,
    input  logic [DEG_W-1:0]     set_deg,
    output logic                 set_done,
    output logic                 set_err,
    output logic [FIELD_W+8:0]   phase_deg,
    output logic                 phase_err,
    output logic                 clk_ref,
    output logic                 clk_out
);
    import phase_clk_pkg::*;

    localparam int PH_W = FIELD_W + 9;
    localparam logic [FIELD_W-1:0] CODE_MAX = '1;

    set_state_t state, nxt;

    logic [RATE_W-1:0]  ratio;
    logic [8:0]         step, step_q;
    logic               bad;
    logic [DEG_W-1:0]   deg_q;
    logic [FIELD_W-1:0] code_q, cur_code;
    logic [31:0]        quo;

    phase_math #(.RATE_W(RATE_W)) u_math (
        .src_rate (src_rate),
        .out_rate (out_rate),
        .ratio    (ratio),
        .step     (step),
        .bad      (bad)
    );

    phase_field #(.FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W)) u_field (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_all  (reg_wr),
        .wdata   (reg_wdata),
        .fld_we  (state == S_COMMIT),
        .fld_val (code_q),
        .ctrl    (reg_rdata)
    );

    assign cur_code = reg_rdata[FIELD_LSB +: FIELD_W];

    phase_div #(.RATE_W(RATE_W), .FIELD_W(FIELD_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio_in (ratio),
        .code_in  (cur_code),
        .clk_ref  (clk_ref),
        .clk_out  (clk_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (set_req) nxt = S_STEP;
            S_STEP:   nxt = bad ? S_FAIL : S_CODE;
            S_CODE:   nxt = S_COMMIT;
            S_COMMIT: nxt = S_IDLE;
            S_FAIL:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_comb quo = div_near(32'(deg_q), 32'(step_q));

    // datapath registers of the sequencer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deg_q  <= '0;
            step_q <= '0;
            code_q <= '0;
        end else begin
            if (state == S_IDLE && set_req) deg_q <= set_deg;
            if (state == S_STEP) step_q <= step;
            if (state == S_CODE) begin
                if (deg_q == DEG_W'(180))            code_q <= '0;
                else if (quo > 32'(CODE_MAX))        code_q <= CODE_MAX;
                else                                 code_q <= FIELD_W'(quo);
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_done  <= 1'b0;
            set_err   <= 1'b0;
            phase_deg <= PH_W'(180);
            phase_err <= 1'b0;
        end else begin
            set_done  <= (state == S_COMMIT) || (state == S_FAIL);
            set_err   <= (state == S_FAIL);
            phase_deg <= (cur_code == '0) ? PH_W'(180) : PH_W'(cur_code) * PH_W'(step);
            phase_err <= (cur_code != '0) && bad;
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> !set_done);
    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |-> set_done);
    p_zero_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code == '0) |=> (phase_deg == PH_W'(180) && !phase_err));
    p_fail_keeps_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FAIL && !reg_wr) |=> $stable(reg_rdata));
endmodule

// File: tb/phase_clk_out_bench.sv
module phase_clk_out_bench;
    localparam int RATE_W = 16;
    localparam int NV = 8;
    localparam logic [31:0] FMASK = 32'h0000_0F00;

    // src, out, degrees, expected code, expected phase, expected lag
    localparam int VEC [NV][6] = '{
        '{1200, 100,  90,  3,  90,  3},
        '{ 800, 100, 180,  0, 180,  4},
        '{ 800, 100, 100,  2,  90,  2},
        '{ 700, 100,  77,  2, 102,  2},
        '{ 700, 100,  25,  0, 180,  3},
        '{ 300, 100, 359,  3, 360,  0},
        '{2000, 100, 400, 15, 270, 15},
        '{1050, 100,  72,  2,  72,  2}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [RATE_W-1:0] src_rate = '0, out_rate = '0;
    logic reg_wr = 1'b0, set_req = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [8:0] set_deg = '0;
    logic set_done, set_err, phase_err, clk_ref, clk_out;
    logic [12:0] phase_deg;

    int nchk = 0, nerr = 0;

    always #2.5 clk = ~clk;

    phase_clk_out u_phase_clk_out (
        .clk(clk), .rst_n(rst_n), .src_rate(src_rate), .out_rate(out_rate),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .set_req(set_req), .set_deg(set_deg), .set_done(set_done), .set_err(set_err),
        .phase_deg(phase_deg), .phase_err(phase_err), .clk_ref(clk_ref), .clk_out(clk_out)
    );

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [31:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic set_phase(input int deg, output int cyc, output bit err);
        @(negedge clk); set_req = 1'b1; set_deg = 9'(deg);
        @(negedge clk); set_req = 1'b0;
        cyc = 1;
        while (!set_done && cyc < 20) begin @(negedge clk); cyc++; end
        err = set_err;
    endtask

    task automatic measure(input int r, input int exp_lag, input string tag);
        logic pr, po;
        int n, per, lag;
        repeat (3 * r + 6) @(negedge clk);
        n = 0;
        do begin pr = clk_ref; po = clk_out; @(negedge clk); n++; end
        while (!(clk_ref && !pr) && n < 4 * r + 8);
        per = 0;
        do begin pr = clk_ref; po = clk_out; @(negedge clk); per++; end
        while (!(clk_ref && !pr) && per < 4 * r + 8);
        chk(per == r, "R1", {tag, " ref period"}, per, r);
        lag = 0;
        while (!(clk_out && !po) && lag < 4 * r + 8) begin po = clk_out; @(negedge clk); lag++; end
        chk(lag == exp_lag, "R2/R3", {tag, " lag"}, lag, exp_lag);
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cyc;
        bit err;
        logic [31:0] base, expv;

        repeat (3) @(negedge clk);
        // R10 reset state
        chk(reg_rdata == 32'd0, "R10", "reset reg", reg_rdata, 0);
        chk(phase_deg == 13'd180 && !phase_err, "R3", "reset phase", phase_deg, 180);
        chk(!set_done && !clk_ref && !clk_out, "R1", "reset outputs low", {set_done, clk_ref, clk_out}, 0);
        rst_n = 1'b1;

        base = 32'hA5A5_A5A5;
        wr_reg(base);
        chk(reg_rdata == base, "R10", "full write", reg_rdata, base);

        for (int i = 0; i < NV; i++) begin
            src_rate = RATE_W'(VEC[i][0]);
            out_rate = RATE_W'(VEC[i][1]);
            set_phase(VEC[i][2], cyc, err);
            chk(cyc == 4 && !err, "R8", $sformatf("row %0d done timing", i), cyc, 4);
            expv = (base & ~FMASK) | (32'(VEC[i][3]) << 8);
            chk(reg_rdata == expv, "R5/R6", $sformatf("row %0d register", i), reg_rdata, expv);
            @(negedge clk);
            chk(phase_deg == 13'(VEC[i][4]) && !phase_err, "R4", $sformatf("row %0d phase", i), phase_deg, VEC[i][4]);
            measure(VEC[i][0] / VEC[i][1], VEC[i][5], $sformatf("row %0d", i));
        end

        // R8: request while busy is ignored; ratio 8, step 45
        src_rate = 16'd800; out_rate = 16'd100;
        @(negedge clk); set_req = 1'b1; set_deg = 9'd45;
        @(negedge clk); set_deg = 9'd135;
        @(negedge clk); set_req = 1'b0;
        cyc = 0;
        while (!set_done && cyc < 20) begin @(negedge clk); cyc++; end
        expv = (base & ~FMASK) | 32'h100;
        chk(reg_rdata == expv, "R8", "busy request ignored", reg_rdata, expv);
        cyc = 0;
        repeat (8) begin @(negedge clk); if (set_done) cyc++; end
        chk(cyc == 0, "R8", "single done pulse", cyc, 0);

        // R7: zero output rate fails and keeps register
        out_rate = 16'd0;
        set_phase(90, cyc, err);
        chk(cyc == 3 && err, "R7", "fail timing", cyc, 3);
        chk(reg_rdata == expv, "R7", "register kept on fail", reg_rdata, expv);
        @(negedge clk);
        chk(phase_err == 1'b1, "R7", "phase_err with code 1", phase_err, 1);
        src_rate = 16'd0; out_rate = 16'd100;
        set_phase(90, cyc, err);
        chk(err == 1'b1, "R7", "zero source rate fails", err, 1);
        // R1: ratio 0 keeps clocks low
        cyc = 0;
        repeat (20) begin @(negedge clk); if (clk_ref || clk_out) cyc++; end
        chk(cyc == 0, "R1", "clocks low when R<2", cyc, 0);
        // R3: code 0 reports 180 without error even with bad rates
        wr_reg(32'h1234_50AB);
        @(negedge clk);
        chk(phase_deg == 13'd180 && !phase_err, "R3", "zero code with bad rates", phase_deg, 180);

        // R10: full write sets code 7; ratio 12 step 30
        src_rate = 16'd1200; out_rate = 16'd100;
        wr_reg(32'h0000_0700);
        chk(reg_rdata == 32'h0000_0700, "R10", "full write code 7", reg_rdata, 32'h700);
        @(negedge clk);
        chk(phase_deg == 13'd210, "R4", "phase of written code", phase_deg, 210);
        measure(12, 7, "full write");

        finish_run();
    end
endmodule